// File: doc/BRIEF.md
# Partitioned Multi-Operand Add Reducer

This block adds a parameterised number of equal-width operands (zero to fifteen, sixteen bits each by default) into a single result. Two run-time split controls can cut the result word at bit 4 and at bit 8. Each cut stops carries at that bit, so the word becomes one, two or three independent lanes. Each lane holds the sum of the matching bit field of every operand, reduced modulo the lane width.

Inside the block, rows of 3:2 carry-save compressors shrink the operand set level by level until two operands remain. A partitioned ripple adder then joins those two. A compressor row drops any carry that would cross an enabled cut. A bit mask parameter chooses which tree levels hold a pipeline register. Level 0 is the raw operand set, level k is the set after k compressor rows, and the level one past the tree depth is the final sum. The split controls travel through the same registers as the operands they belong to. The block accepts a new operand set on every clock. If no level is selected, the path from inputs to output is purely combinational. A mask that selects a level beyond the final sum stops elaboration with an error.

Top module: `madd_reducer`

## Requirements
- R1: With both split controls low, `sum_o` equals the sum of all operands modulo 2^16. With only `hi_split_i` high, bits [15:8] and [7:0] are separate lanes. With only `lo_split_i` high, bits [15:4] and [3:0] are separate lanes. With both high, bits [15:8], [7:4] and [3:0] are separate lanes. Each lane equals the lane mask ANDed with the sum of (operand AND lane mask) over all operands.
- R2: When the operand count parameter is 0, `sum_o` is 0 whatever the operand input carries.
- R3: The delay from inputs to `sum_o`, in clock cycles, equals the number of bits set in the level mask.
- R4: With an all-zero level mask, `sum_o` reflects the current inputs in the same cycle.
- R5: No carry crosses an enabled cut. For example, with all operands at 0xFFFF or 0x0111, each lane holds only its own wrapped sum.
- R6: A synchronous active-high reset clears every pipeline register, so `sum_o` reads 0 in the cycle after reset when any level is registered.
- R7: A new operand set is accepted on every clock, and consecutive results appear on consecutive clocks.
- R8: Each result uses the split controls applied together with its own operands, even when the controls change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| op_vec_i | input | max(N_IN,1)*W | Operands packed low to high, operand i at bits [i*W +: W] |
| lo_split_i | input | 1 | Cuts carries into bit P_LO (4) |
| hi_split_i | input | 1 | Cuts carries into bit P_HI (8) |
| sum_o | output | W | Lane-partitioned sum |

## Verification
The hardest case to reach is a registered pipeline in which the split controls change on every clock. If the controls were not delayed together with the operands, a result would be split under its neighbour's setting, and a run that holds the controls steady would never show the fault. After directed blocks of all-zero, all-ones and 0x0111 operands in each of the four split modes, the stimulus picks a fresh split mode and fresh pseudo-random operands every cycle. A latency-aware queue of expected sums follows each result down the pipeline. Three instances run side by side: a registered seven-operand instance, a combinational fifteen-operand instance and an empty one.

// File: rtl/madd_pkg.sv
package madd_pkg;

  // operand count left after one row of 3:2 compressors
  function automatic int csa_next(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // operand count after s compressor rows
  function automatic int ops_at(input int n, input int s);
    int m;
    m = n;
    for (int k = 0; k < s; k++) m = csa_next(m);
    return m;
  endfunction

  // compressor rows needed to reach two operands or fewer
  function automatic int tree_depth(input int n);
    int m;
    int d;
    m = n;
    d = 0;
    while (m > 2) begin
      m = csa_next(m);
      d++;
    end
    return d;
  endfunction

  function automatic int count_set(input logic [31:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/madd_csa_row.sv
module madd_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] cut_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  logic [W-1:0] maj;

  assign sum_o = a_i ^ b_i ^ c_i;
  assign maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // carry of bit i lands on bit i+1 unless a lane boundary sits there
  assign cry_o = {maj[W-2:0], 1'b0} & ~cut_i;
endmodule

// File: rtl/madd_part_adder.sv
module madd_part_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] cut_i,
  output logic [W-1:0] sum_o
);
  always_comb begin
    logic c;
    logic cin;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      cin      = cut_i[i] ? 1'b0 : c;
      sum_o[i] = a_i[i] ^ b_i[i] ^ cin;
      c        = (a_i[i] & b_i[i]) | (a_i[i] & cin) | (b_i[i] & cin);
    end
  end
endmodule

// File: rtl/madd_lvl_reg.sv
module madd_lvl_reg #(
  parameter int DW = 8,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  generate
    if (EN) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_i;
      end
      assign q_o = q;
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/madd_reducer.sv
module madd_reducer
  import madd_pkg::*;
#(
  parameter int          N_IN     = 7,
  parameter int          W        = 16,
  parameter int          P_LO     = 4,
  parameter int          P_HI     = 8,
  parameter logic [31:0] REG_MASK = 32'b10_0100
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [((N_IN > 0) ? N_IN : 1)*W-1:0]  op_vec_i,
  input  logic                                  lo_split_i,
  input  logic                                  hi_split_i,
  output logic [W-1:0]                          sum_o
);
  localparam int NOPS    = (N_IN > 2) ? N_IN : 2;
  localparam int DEPTH   = tree_depth(N_IN);
  localparam int OUT_LVL = DEPTH + 1;
  localparam int LAT     = count_set(REG_MASK);
  localparam bit BAD_MSK = (OUT_LVL < 31) ? ((REG_MASK >> (OUT_LVL + 1)) != 0) : 1'b0;

  generate
    if (BAD_MSK) begin : g_bad_mask
      $error("level mask selects a level beyond the final sum");
    end
  endgenerate

  logic [NOPS*W-1:0] lvl_raw [0:DEPTH];
  logic [W-1:0]      cut_raw [0:DEPTH];
  logic [NOPS*W-1:0] lvl_d   [0:DEPTH];
  logic [W-1:0]      lvl_cut [0:DEPTH];
  logic [W-1:0]      sum_raw;

  // level 0: raw operands and lane cuts
  generate
    if (N_IN > 0) begin : g_in
      if (NOPS > N_IN) begin : g_pad
        assign lvl_raw[0] = {{((NOPS - N_IN) * W){1'b0}}, op_vec_i};
      end else begin : g_full
        assign lvl_raw[0] = op_vec_i;
      end
    end else begin : g_none
      assign lvl_raw[0] = '0;
    end
  endgenerate

  always_comb begin
    cut_raw[0]       = '0;
    cut_raw[0][P_LO] = lo_split_i;
    cut_raw[0][P_HI] = hi_split_i;
  end

  // optional register at every tree level, cuts travel with data
  for (genvar k = 0; k <= DEPTH; k++) begin : g_lvl
    logic [NOPS*W+W-1:0] pk_d;
    logic [NOPS*W+W-1:0] pk_q;
    assign pk_d = {cut_raw[k], lvl_raw[k]};
    madd_lvl_reg #(.DW(NOPS*W+W), .EN(REG_MASK[k])) u_reg (
      .clk (clk),
      .rst (rst),
      .d_i (pk_d),
      .q_o (pk_q)
    );
    assign lvl_cut[k] = pk_q[NOPS*W +: W];
    assign lvl_d[k]   = pk_q[NOPS*W-1:0];
  end

  // compressor rows
  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    localparam int CNT  = ops_at(N_IN, k);
    localparam int GRP  = CNT / 3;
    localparam int REM  = CNT % 3;
    localparam int NEXT = csa_next(CNT);

    assign cut_raw[k+1] = lvl_cut[k];

    for (genvar g = 0; g < GRP; g++) begin : g_csa
      madd_csa_row #(.W(W)) u_csa (
        .a_i   (lvl_d[k][(3*g)*W +: W]),
        .b_i   (lvl_d[k][(3*g+1)*W +: W]),
        .c_i   (lvl_d[k][(3*g+2)*W +: W]),
        .cut_i (lvl_cut[k]),
        .sum_o (lvl_raw[k+1][(2*g)*W +: W]),
        .cry_o (lvl_raw[k+1][(2*g+1)*W +: W])
      );
    end
    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign lvl_raw[k+1][(2*GRP+r)*W +: W] = lvl_d[k][(3*GRP+r)*W +: W];
    end
    if (NEXT < NOPS) begin : g_zero
      assign lvl_raw[k+1][NOPS*W-1:NEXT*W] = '0;
    end
  end

  // final two-operand partitioned add and optional output register
  madd_part_adder #(.W(W)) u_fin (
    .a_i   (lvl_d[DEPTH][0 +: W]),
    .b_i   (lvl_d[DEPTH][W +: W]),
    .cut_i (lvl_cut[DEPTH]),
    .sum_o (sum_raw)
  );

  madd_lvl_reg #(.DW(W), .EN(REG_MASK[OUT_LVL])) u_out (
    .clk (clk),
    .rst (rst),
    .d_i (sum_raw),
    .q_o (sum_o)
  );

  // ---------------------------------------------------------------- checks
  function automatic logic [W-1:0] lane_total(input logic [NOPS*W-1:0] ops,
                                              input logic [W-1:0] cut);
    logic [W-1:0] res;
    logic [W-1:0] acc;
    logic [W-1:0] msk;
    int lo;
    res = '0;
    lo  = 0;
    for (int i = 1; i <= W; i++) begin
      if ((i == W) || cut[i % W]) begin
        msk = '0;
        for (int j = 0; j < W; j++) msk[j] = (j >= lo) && (j < i);
        acc = '0;
        for (int o = 0; o < NOPS; o++) acc = acc + (ops[o*W +: W] & msk);
        res = res | (acc & msk);
        lo  = i;
      end
    end
    return res;
  endfunction

  logic [W-1:0] ref_now;
  assign ref_now = lane_total(lvl_raw[0], cut_raw[0]);

  for (genvar k = 0; k < DEPTH; k++) begin : g_row_chk
    AST_ROW_CONSERVE: assert property (@(posedge clk) disable iff (rst)
      lane_total(lvl_raw[k+1], lvl_cut[k]) == lane_total(lvl_d[k], lvl_cut[k])); // R1
  end

  AST_FINAL_LANES: assert property (@(posedge clk) disable iff (rst)
    sum_raw == lane_total(lvl_d[DEPTH], lvl_cut[DEPTH])); // R5

  generate
    if (LAT == 0) begin : g_chk_comb
      AST_COMB_PATH: assert property (@(posedge clk) disable iff (rst)
        sum_o == ref_now); // R4
    end else begin : g_chk_pipe
      logic [5:0] age;
      always_ff @(posedge clk) begin
        if (rst)               age <= '0;
        else if (age != 6'h3F) age <= age + 6'd1;
      end
      AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (int'(age) >= LAT) |-> (sum_o == $past(ref_now, LAT))); // R3
      AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_o == '0)); // R6
    end
  endgenerate

endmodule

// File: tb/madd_reducer_tb.sv
`timescale 1ns/100ps
module madd_reducer_tb;
  localparam real HALF = 2.5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lo_en = 1'b0;
  logic         hi_en = 1'b0;
  logic [239:0] bus = '0;
  logic [15:0]  vin [15];
  logic [15:0]  y_pipe, y_comb, y_empty;
  logic [15:0]  hist [8];
  int n_chk = 0;
  int n_bad = 0;

  always #HALF clk = ~clk;

  madd_reducer #(.N_IN(7), .REG_MASK(32'b10_0100)) u_dut (
    .clk(clk), .rst(rst), .op_vec_i(bus[111:0]),
    .lo_split_i(lo_en), .hi_split_i(hi_en), .sum_o(y_pipe));

  madd_reducer #(.N_IN(15), .REG_MASK(32'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .op_vec_i(bus),
    .lo_split_i(lo_en), .hi_split_i(hi_en), .sum_o(y_comb));

  madd_reducer #(.N_IN(0), .REG_MASK(32'b1)) u_dut_empty (
    .clk(clk), .rst(rst), .op_vec_i(bus[15:0]),
    .lo_split_i(lo_en), .hi_split_i(hi_en), .sum_o(y_empty));

  function automatic logic [15:0] ref_sum(input int n, input bit plo, input bit phi);
    logic [15:0] m [3];
    int nm;
    logic [15:0] y;
    case ({plo, phi})
      2'b00: begin m[0] = 16'hFFFF; nm = 1; end
      2'b01: begin m[0] = 16'hFF00; m[1] = 16'h00FF; nm = 2; end
      2'b10: begin m[0] = 16'hFFF0; m[1] = 16'h000F; nm = 2; end
      default: begin m[0] = 16'hFF00; m[1] = 16'h00F0; m[2] = 16'h000F; nm = 3; end
    endcase
    y = '0;
    for (int k = 0; k < nm; k++) begin
      int acc;
      acc = 0;
      for (int i = 0; i < n; i++) acc += int'(vin[i] & m[k]);
      y |= m[k] & acc[15:0];
    end
    return y;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit r, input int key, input bit plo, input bit phi);
    logic [15:0] e7, e15;
    @(negedge clk);
    rst   = r;
    lo_en = plo;
    hi_en = phi;
    for (int i = 0; i < 15; i++) begin
      case (key)
        0: vin[i] = 16'h0000;
        1: vin[i] = 16'hFFFF;
        2: vin[i] = 16'h0111;
        default: vin[i] = 16'($urandom);
      endcase
      bus[i*16 +: 16] = vin[i];
    end
    #1;
    e7  = ref_sum(7, plo, phi);
    e15 = ref_sum(15, plo, phi);
    for (int h = 7; h > 0; h--) hist[h] = hist[h-1];
    hist[0] = r ? 16'h0000 : e7;
    if ((key == 1 || key == 2) && (plo || phi)) check("R5/R4", y_comb, e15);
    else                                        check("R1/R4", y_comb, e15);
    if (r) check("R6", y_pipe, 16'h0000);
    else   check("R3/R7/R8", y_pipe, hist[2]);
    check("R2", y_empty, 16'h0000);
  endtask

  initial begin
    #(HALF * 2.0 * 100000.0);
    n_bad++;
    $display("FAIL R7 watchdog: got no end of run, expected end within limit");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int h = 0; h < 8; h++) hist[h] = '0;
    for (int i = 0; i < 15; i++) vin[i] = '0;
    repeat (2) @(posedge clk);
    // reset with live inputs (R6)
    for (int c = 0; c < 4; c++) step(1'b1, 5, c[0], c[1]);
    // directed patterns in each split mode (R1, R5)
    for (int md = 0; md < 4; md++)
      for (int key = 0; key < 8; key++)
        step(1'b0, key, md[1], md[0]);
    // split mode and operands change every cycle (R7, R8)
    for (int c = 0; c < 300; c++) begin
      int sel;
      sel = int'($urandom % 10);
      step(1'b0, (sel < 3) ? sel : 5, 1'($urandom), 1'($urandom));
    end
    // drain the pipeline with zeros
    for (int c = 0; c < 4; c++) step(1'b0, 0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule